// File: doc/BRIEF.md
# Double-Rate Burst SRAM with Split Read and Write Ports

This block is a synthesizable storage model with one write data port and one read data port that run side by side. Each request moves two words, the aligned even word first and its odd partner second, one word per clock phase. A read and a write can both be latched at the same main-clock edge. The write data port takes its two words and its per-byte write strobes on consecutive phases. The read data port returns its two words on consecutive phases, starting one main cycle after the request. Outside those two phases the read data port is left floating and a valid flag is low.

The double-rate clocks are modelled with a single fast clock running at twice the main rate. An internal phase bit marks which fast edge stands for the main-clock rise and which stands for its complement. The `main_edge_o` output shows that bit. A requester drives requests and first-beat write data while `main_edge_o` is high, and drives second-beat write data in the fast cycle after that.

Top module: `ddr_burst_sram`

## Requirements
- R1: After reset `rvalid_o` is 0, `rdata_o` is high impedance, and `main_edge_o` is 1, so the first fast edge after reset is a main edge.
- R2: A write latched at main edge E with `addr_i` = A stores the first beat at word {A[AW-1:1],0}. It stores the second beat, taken at fast edge E+1, at word {A[AW-1:1],1}. The value of A[0] has no effect.
- R3: A read latched at main edge E drives word {A[AW-1:1],0} with `rvalid_o`=1 from fast edge E+2 to E+3. It then drives word {A[AW-1:1],1} with `rvalid_o`=1 from E+3 to E+4.
- R4: `wbyte_n` bit b (active low) enables bits [9b+8:9b] of the stored word. A byte whose bit is 1 keeps its old contents.
- R5: `wbyte_n` is sampled separately for each beat, so the two words of one write may use different byte masks.
- R6: If `rd_sel_n` and `wr_sel_n` are both 1 at a main edge, no word is changed and `rvalid_o` is 0 in the window a read would have used.
- R7: `rvalid_o` is 1 exactly in the fast cycles in which read data is driven. In every other cycle `rdata_o` is high impedance.
- R8: When a read and a write to the same word pair are latched at the same main edge, the read returns both words as they were before that write.
- R9: Requests on consecutive main edges are accepted on each port. Two back-to-back reads give four valid words with no gap.
- R10: `main_edge_o` alternates value at every fast edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per main cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_edge_o | output | 1 | High when the next fast edge is a main-clock edge |
| rd_sel_n | input | 1 | Active-low read request, sampled at main edges |
| wr_sel_n | input | 1 | Active-low write request, sampled at main edges |
| addr_i | input | AW | Word address; bit 0 is ignored |
| wdata_i | input | NBYTES*BYTE_W | Write data, beat 0 at the main edge, beat 1 at the next fast edge |
| wbyte_n | input | NBYTES | Active-low byte write enables, one per byte, for each beat |
| rdata_o | output | NBYTES*BYTE_W | Read data, high impedance when not valid |
| rvalid_o | output | 1 | High while `rdata_o` carries a read word |

## Verification
Counting fast edges from the main edge E that latches a read, the first word is due after edge E+2 and the second word after E+3. The valid flag must be low again after E+4 unless another read followed. A write is not visible in the moment it lands; it shows up only through a later read, whose words follow the same E+2 and E+3 timing. The bench drives every input at a falling edge and samples `rdata_o` and `rvalid_o` at the falling edge that follows each of these rising edges. It counts falling edges from the request to find each sample point. A reference array inside the bench gives the expected words.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;
    typedef enum logic {
        PH_MAIN = 1'b0,
        PH_COMP = 1'b1
    } phase_e;
endpackage

// File: rtl/ddr_phase_gen.sv
module ddr_phase_gen
    import ddr_sram_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);
    typedef struct packed {
        phase_e ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.ph = (st_q.ph == PH_MAIN) ? PH_COMP : PH_MAIN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_MAIN};
        else        st_q <= st_d;
    end

    assign phase_o = st_q.ph;
endmodule

// File: rtl/ddr_sram_store.sv
module ddr_sram_store #(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [NBYTES-1:0] wbe,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-2:0]     rpair,
    output logic [DW-1:0]     rword0,
    output logic [DW-1:0]     rword1
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
        end

        assign rword0[b*BYTE_W +: BYTE_W] = lane_mem[{rpair, 1'b0}];
        assign rword1[b*BYTE_W +: BYTE_W] = lane_mem[{rpair, 1'b1}];
    end
endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
    import ddr_sram_pkg::*;
#(
    parameter int AW     = 8,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [NBYTES-1:0] wbyte_n,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [NBYTES-1:0] mem_be
);
    typedef struct packed {
        logic          pend;
        logic [AW-2:0] pair;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        mem_we   = 1'b0;
        mem_addr = '0;
        mem_be   = ~wbyte_n;
        if (phase == PH_MAIN) begin
            st_d.pend = !wr_sel_n;
            if (!wr_sel_n) begin
                st_d.pair = addr_i[AW-1:1];
                mem_we    = 1'b1;
                mem_addr  = {addr_i[AW-1:1], 1'b0};
            end
        end else begin
            st_d.pend = 1'b0;
            if (st_q.pend) begin
                mem_we   = 1'b1;
                mem_addr = {st_q.pair, 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ddr_rd_pipe.sv
module ddr_rd_pipe
    import ddr_sram_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          rd_sel_n,
    input  logic [DW-1:0] rword0,
    input  logic [DW-1:0] rword1,
    output logic [DW-1:0] out_data,
    output logic          out_valid
);
    typedef struct packed {
        logic          pend;
        logic [DW-1:0] buf0;
        logic [DW-1:0] buf1;
        logic [DW-1:0] hold;
        logic          hold_v;
        logic [DW-1:0] out;
        logic          out_v;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase == PH_MAIN) begin
            st_d.out    = st_q.buf0;
            st_d.out_v  = st_q.pend;
            st_d.hold   = st_q.buf1;
            st_d.hold_v = st_q.pend;
            st_d.pend   = !rd_sel_n;
            if (!rd_sel_n) begin
                st_d.buf0 = rword0;
                st_d.buf1 = rword1;
            end
        end else begin
            st_d.out    = st_q.hold;
            st_d.out_v  = st_q.hold_v;
            st_d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data  = st_q.out;
    assign out_valid = st_q.out_v;
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
    import ddr_sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              main_edge_o,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NBYTES-1:0] wbyte_n,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o
);
    phase_e            phase;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [NBYTES-1:0] mem_be;
    logic [DW-1:0]     rword0, rword1, out_data;
    logic              out_valid;

    ddr_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    ddr_wr_seq #(.AW(AW), .NBYTES(NBYTES)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .wr_sel_n (wr_sel_n),
        .addr_i   (addr_i),
        .wbyte_n  (wbyte_n),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_be   (mem_be)
    );

    ddr_sram_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_addr),
        .wbe    (mem_be),
        .wdata  (wdata_i),
        .rpair  (addr_i[AW-1:1]),
        .rword0 (rword0),
        .rword1 (rword1)
    );

    ddr_rd_pipe #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .rd_sel_n  (rd_sel_n),
        .rword0    (rword0),
        .rword1    (rword1),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    assign main_edge_o = (phase == PH_MAIN);
    assign rvalid_o    = out_valid;
    assign rdata_o     = out_valid ? out_data : {DW{1'bz}};
endmodule

// File: rtl/ddr_burst_sram_chk.sv
module ddr_burst_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          main_edge_o,
    input logic          rd_sel_n,
    input logic          rvalid_o,
    input logic [DW-1:0] rdata_o
);
    // R10: phase flag alternates
    assert_phase_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (main_edge_o != $past(main_edge_o)));

    // R3: first read word is valid after E+2
    assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_edge_o && !rd_sel_n) |-> ##3 rvalid_o);

    // R3: second read word is valid after E+3
    assert_second_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_edge_o && !rd_sel_n) |-> ##4 rvalid_o);

    // R6: no read request gives no valid data in its window
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (main_edge_o && rd_sel_n) |-> ##3 (!rvalid_o ##1 !rvalid_o));

    // R7: a first beat (seen after a main edge) is always followed by a second
    assert_beat_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && !main_edge_o) |=> rvalid_o);

    // R7: driven data is fully known
    assert_data_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !$isunknown(rdata_o));
endmodule

bind ddr_burst_sram ddr_burst_sram_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_edge_o (main_edge_o),
    .rd_sel_n    (rd_sel_n),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
);

// File: tb/ddr_burst_sram_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_sram_tb_top;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          main_edge_o;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [1:0]    wbyte_n = 2'b11;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    ddr_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .main_edge_o(main_edge_o),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr_i(addr_i),
        .wdata_i(wdata_i), .wbyte_n(wbyte_n), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                            input logic [1:0] bw);
        logic [DW-1:0] r = old;
        if (!bw[0]) r[8:0]  = d[8:0];
        if (!bw[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    task automatic wait_main();
        @(negedge clk);
        while (!main_edge_o) @(negedge clk);
    endtask

    // one main cycle of requests; returns at the falling edge after main edge E
    task automatic issue(input bit rd, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d0, input logic [1:0] bw0,
                         input logic [DW-1:0] d1, input logic [1:0] bw1);
        logic [AW-1:0] w0 = {a[AW-1:1], 1'b0};
        wait_main();
        rd_sel_n = !rd; wr_sel_n = !wr; addr_i = a; wdata_i = d0; wbyte_n = bw0;
        @(negedge clk);
        rd_sel_n = 1'b1; wr_sel_n = 1'b1; wdata_i = d1; wbyte_n = bw1;
        if (wr) begin
            ref_mem[w0]      = merge(ref_mem[w0], d0, bw0);
            ref_mem[w0 + 1]  = merge(ref_mem[w0 + 1], d1, bw1);
        end
    endtask

    // after issue(): sample both read beats at E+2 and E+3, then idle at E+4
    task automatic expect_read(input string req, input logic [DW-1:0] e0, input logic [DW-1:0] e1);
        @(negedge clk);
        @(negedge clk);
        check({req, " valid0"}, rvalid_o, 1);
        check({req, " word0"}, rdata_o, e0);
        @(negedge clk);
        check({req, " valid1"}, rvalid_o, 1);
        check({req, " word1"}, rdata_o, e1);
        @(negedge clk);
        check({req, " idle after burst R7"}, rvalid_o, 0);
    endtask

    task automatic t_reset();
        check("R1 valid low", rvalid_o, 0);
        check("R1 main edge first", main_edge_o, 1);
        @(negedge clk);
        check("R10 phase alternates", main_edge_o, 0);
        @(negedge clk);
        check("R10 phase alternates back", main_edge_o, 1);
    endtask

    task automatic t_write_read();
        issue(0, 1, 8'h21, 18'h1A5A5, 2'b00, 18'h25A5A, 2'b00);
        issue(1, 0, 8'h20, '0, 2'b11, '0, 2'b11);
        expect_read("R2 R3 burst pair", 18'h1A5A5, 18'h25A5A);
        issue(0, 1, 8'hFE, 18'h3FFFF, 2'b00, 18'h00001, 2'b00);
        issue(1, 0, 8'hFF, '0, 2'b11, '0, 2'b11);
        expect_read("R2 top pair odd addr", 18'h3FFFF, 18'h00001);
    endtask

    task automatic t_byte_mask();
        issue(0, 1, 8'h40, 18'h2AAAA, 2'b00, 18'h15555, 2'b00);
        issue(0, 1, 8'h40, 18'h3FFFF, 2'b01, 18'h3FFFF, 2'b10);
        issue(1, 0, 8'h40, '0, 2'b11, '0, 2'b11);
        expect_read("R4 byte mask", ref_mem[8'h40], ref_mem[8'h41]);
        check("R4 upper only", ref_mem[8'h40], 18'h3FEAA);
    endtask

    task automatic t_per_beat();
        issue(0, 1, 8'h50, 18'h00000, 2'b00, 18'h00000, 2'b00);
        issue(0, 1, 8'h50, 18'h12345, 2'b10, 18'h2BCDE, 2'b01);
        issue(1, 0, 8'h50, '0, 2'b11, '0, 2'b11);
        expect_read("R5 per-beat masks", 18'h00145, 18'h2BC00);
    endtask

    task automatic t_nop();
        issue(0, 1, 8'h60, 18'h11111, 2'b00, 18'h22222, 2'b00);
        issue(0, 0, 8'h60, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00);
        @(negedge clk);
        @(negedge clk);
        check("R6 nop no valid beat0", rvalid_o, 0);
        @(negedge clk);
        check("R6 nop no valid beat1", rvalid_o, 0);
        issue(1, 0, 8'h60, '0, 2'b11, '0, 2'b11);
        expect_read("R6 nop leaves data", 18'h11111, 18'h22222);
    endtask

    task automatic t_same_edge();
        logic [DW-1:0] o0, o1;
        issue(0, 1, 8'h70, 18'h0AAAA, 2'b00, 18'h0BBBB, 2'b00);
        o0 = ref_mem[8'h70];
        o1 = ref_mem[8'h71];
        issue(1, 1, 8'h71, 18'h0CCCC, 2'b00, 18'h0DDDD, 2'b00);
        expect_read("R8 read before write", o0, o1);
        issue(1, 0, 8'h70, '0, 2'b11, '0, 2'b11);
        expect_read("R8 write then landed", 18'h0CCCC, 18'h0DDDD);
    endtask

    task automatic t_back_to_back();
        issue(0, 1, 8'h80, 18'h00A01, 2'b00, 18'h00A02, 2'b00);
        issue(0, 1, 8'h82, 18'h00B01, 2'b00, 18'h00B02, 2'b00);
        issue(1, 0, 8'h80, '0, 2'b11, '0, 2'b11);
        @(negedge clk);
        check("R9 second read main", main_edge_o, 1);
        rd_sel_n = 1'b0; addr_i = 8'h82;
        @(negedge clk);
        rd_sel_n = 1'b1;
        check("R9 b2b word0", rdata_o, 18'h00A01);
        check("R9 b2b valid0", rvalid_o, 1);
        @(negedge clk);
        check("R9 b2b word1", rdata_o, 18'h00A02);
        @(negedge clk);
        check("R9 b2b word2", rdata_o, 18'h00B01);
        check("R9 b2b valid2", rvalid_o, 1);
        @(negedge clk);
        check("R9 b2b word3", rdata_o, 18'h00B02);
        @(negedge clk);
        check("R9 R7 idle after pair", rvalid_o, 0);
    endtask

    bit done = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_byte_mask();
        t_per_beat();
        t_nop();
        t_same_edge();
        t_back_to_back();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule